// File: doc/BRIEF.md
# Gated Cycle-Count Frequency Meter

This block measures how fast an unknown oscillator runs, using a known reference clock as the timebase. Software writes a 24-bit window length, expressed in cycles of the oscillator under test, into the control register. It then sets the detect-enable bit. While detection and the free-run clock enable are both set, the meter counts reference-clock cycles. The count stops when the oscillator has completed the programmed number of cycles.

The oscillator's edges reach the reference domain through a toggle flop and a multi-stage synchronizer. When the window closes, the reference count is frozen into a read-only result register and a valid flag is raised in the status register. Software polls that flag. A result of zero means the measurement failed. A timeout of 200 µs worth of reference cycles ends a measurement that never completes: valid stays low and the result stays zero. The oscillator frequency is then the window length times the reference frequency, divided by the result.

Top module: `freqmeter_top`

## Requirements
- R1: After reset, the control word (address 0), the status word (address 1) and the result word (address 2) all read as zero.
- R2: At address 0, bits 23:0 hold the window length and bit 24 holds detect enable. Both read back as written.
- R3: At address 1, bit 8 is the free-run clock enable and reads back as written. Bit 0 is the valid flag; writes to it are ignored.
- R4: The result is read from address 2, zero-extended, and writes to that address are ignored.
- R5: With both enables set, valid rises once the synchronized oscillator edge count reaches the window length. The result is then the number of reference cycles that elapsed, within a few cycles of synchronizer latency.
- R6: While the free-run clock enable is clear, neither the edge count nor the reference count advances. A measurement resumes when the enable returns.
- R7: Clearing detect enable aborts a measurement and clears valid on the next cycle. Setting it again starts from zero counts.
- R8: The reference counter saturates at all ones instead of wrapping, and that value is reported with valid set.
- R9: If TIMEOUT_CYC reference cycles pass after detection starts without the window closing, the measurement ends with valid low and the result zero.
- R10: A window length of zero never sets valid.
- R11: The window length is captured when detection starts. Changing it during a measurement has no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all registers live in this domain |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cut_clk | input | 1 | Clock of the oscillator under test |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 control, 1 status, 2 result) |
| wdata | input | 25 | Write data |
| rdata | output | 32 | Read data for the addressed register, combinational |

## Verification
A stuck or mis-sequenced measurement state appears at the ports as a status word whose valid bit never rises, rises after an abort, or rises for a zero window. A broken edge synchronizer or counter shows up in the result register. The count then drifts away from window length times the period ratio as soon as the first measurement completes, a few hundred reference cycles after detection is enabled. A counter that wraps instead of saturating, or a window length that is not latched at the start, shows up only in the single measurement that exercises that case. A faulty timeout path is seen only after the full timeout interval has elapsed.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int CNT_W     = 24;
  localparam int DATA_W    = 32;
  localparam int WIN_W     = CNT_W + 1;
  localparam int ADDR_W    = 2;
  localparam int DET_BIT   = CNT_W;
  localparam int RUN_BIT   = 8;
  localparam int VALID_BIT = 0;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 2'd1;
  localparam logic [ADDR_W-1:0] A_RES  = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2,
    ST_TOUT = 2'd3
  } meas_st_e;
endpackage

// File: rtl/fm_rst_sync.sv
module fm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_sync_n = stg2_q;
endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic cut_clk,
  output logic edge_pulse_o
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic tog_q;
  logic [CHAIN_W-1:0] chain_q;

  // one toggle per rising edge of the clock under test
  always_ff @(posedge cut_clk or negedge rst_n) begin
    if (!rst_n) tog_q <= 1'b0;
    else        tog_q <= ~tog_q;
  end

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= tog_q;
  end

  genvar gi;
  generate
    for (gi = 1; gi < CHAIN_W; gi++) begin : g_stage
      always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else        chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  // a change between the last two stages marks one synchronized edge
  assign edge_pulse_o = chain_q[CHAIN_W-1] ^ chain_q[CHAIN_W-2];
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int REF_W       = 24,
  parameter int TIMEOUT_CYC = 25000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             det_en_i,
  input  logic             run_en_i,
  input  logic [CNT_W-1:0] win_len_i,
  input  logic             edge_pulse_i,
  output logic             valid_o,
  output logic [REF_W-1:0] result_o
);
  localparam int                 TMO_W   = $clog2(TIMEOUT_CYC + 1);
  localparam logic [TMO_W-1:0]   TMO_END = TMO_W'(TIMEOUT_CYC - 1);
  localparam logic [REF_W-1:0]   REF_MAX = {REF_W{1'b1}};
  localparam logic [CNT_W-1:0]   ONE_E   = CNT_W'(1);
  localparam logic [REF_W-1:0]   ONE_R   = REF_W'(1);
  localparam logic [TMO_W-1:0]   ONE_T   = TMO_W'(1);

  meas_st_e         state_q, state_d;
  logic [CNT_W-1:0] edge_q, edge_d;
  logic [CNT_W-1:0] nlat_q, nlat_d;
  logic [REF_W-1:0] ref_q, ref_d;
  logic [REF_W-1:0] res_q, res_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;
  logic             active;
  logic             win_close;

  assign active    = det_en_i & run_en_i;
  assign win_close = active && edge_pulse_i && (nlat_q != '0) && ((edge_q + ONE_E) == nlat_q);

  always_comb begin
    state_d = state_q;
    edge_d  = edge_q;
    nlat_d  = nlat_q;
    ref_d   = ref_q;
    res_d   = res_q;
    tmo_d   = tmo_q;
    unique case (state_q)
      ST_IDLE: begin
        if (det_en_i) begin
          state_d = ST_RUN;
          edge_d  = '0;
          ref_d   = '0;
          res_d   = '0;
          tmo_d   = '0;
          nlat_d  = win_len_i;
        end
      end
      ST_RUN: begin
        if (!det_en_i) begin
          state_d = ST_IDLE;
        end else begin
          tmo_d = tmo_q + ONE_T;
          if (active) begin
            ref_d = (ref_q == REF_MAX) ? ref_q : ref_q + ONE_R;
            if (edge_pulse_i) edge_d = edge_q + ONE_E;
          end
          if (win_close) begin
            state_d = ST_DONE;
            res_d   = ref_d;
          end else if (tmo_q == TMO_END) begin
            state_d = ST_TOUT;
          end
        end
      end
      default: begin
        if (!det_en_i) state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      edge_q  <= '0;
      nlat_q  <= '0;
      ref_q   <= '0;
      res_q   <= '0;
      tmo_q   <= '0;
    end else begin
      state_q <= state_d;
      edge_q  <= edge_d;
      nlat_q  <= nlat_d;
      ref_q   <= ref_d;
      res_q   <= res_d;
      tmo_q   <= tmo_d;
    end
  end

  assign valid_o  = (state_q == ST_DONE);
  assign result_o = res_q;

  // R6: gated clock enable freezes both counters
  a_r6_hold_when_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && det_en_i && !run_en_i) |=> ($stable(ref_q) && $stable(edge_q)));

  // R7: dropping detect enable returns to idle on the next cycle
  a_r7_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!det_en_i) |=> (state_q == ST_IDLE));

  // R8: reference counter never wraps from all ones
  a_r8_ref_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && det_en_i && ref_q == REF_MAX) |=> (ref_q == REF_MAX));

  // R9: a timed-out measurement reports zero
  a_r9_timeout_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TOUT) |-> (res_q == '0));

  // R10: completion only with a nonzero latched window
  a_r10_zero_never_done: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DONE) |-> (nlat_q != '0));
endmodule

// File: rtl/fm_regs.sv
module fm_regs
  import fm_pkg::*;
#(
  parameter int REF_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WIN_W-1:0]  wdata,
  input  logic              valid_i,
  input  logic [REF_W-1:0]  result_i,
  output logic [CNT_W-1:0]  win_len_o,
  output logic              det_en_o,
  output logic              run_en_o,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] win_q, win_d;
  logic             det_q, det_d;
  logic             run_q, run_d;
  logic             ctrl_we, stat_we;

  assign ctrl_we = wr_en && (addr == A_CTRL);
  assign stat_we = wr_en && (addr == A_STAT);

  always_comb begin
    win_d = win_q;
    det_d = det_q;
    run_d = run_q;
    if (ctrl_we) begin
      win_d = wdata[CNT_W-1:0];
      det_d = wdata[DET_BIT];
    end
    if (stat_we) run_d = wdata[RUN_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      det_q <= 1'b0;
      run_q <= 1'b0;
    end else begin
      win_q <= win_d;
      det_q <= det_d;
      run_q <= run_d;
    end
  end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL: rdata = DATA_W'({det_q, win_q});
      A_STAT: begin
        rdata[RUN_BIT]   = run_q;
        rdata[VALID_BIT] = valid_i;
      end
      A_RES:   rdata = DATA_W'(result_i);
      default: rdata = '0;
    endcase
  end

  assign win_len_o = win_q;
  assign det_en_o  = det_q;
  assign run_en_o  = run_q;

  // R3: the enable bit only changes through a status write
  a_r3_run_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!stat_we) |=> $stable(run_q));
endmodule

// File: rtl/freqmeter_top.sv
module freqmeter_top
  import fm_pkg::*;
#(
  parameter int REF_W       = 24,
  parameter int TIMEOUT_CYC = 25000,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   ref_clk,
  input  logic                   rst_n,
  input  logic                   cut_clk,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [WIN_W-1:0]       wdata,
  output logic [DATA_W-1:0]      rdata
);
  logic             rst_sync_n;
  logic             edge_pulse;
  logic             det_en, run_en, valid;
  logic [CNT_W-1:0] win_len;
  logic [REF_W-1:0] result;

  fm_rst_sync u_rst (
    .clk        (ref_clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fm_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .ref_clk      (ref_clk),
    .rst_n        (rst_sync_n),
    .cut_clk      (cut_clk),
    .edge_pulse_o (edge_pulse)
  );

  fm_ctrl #(.REF_W(REF_W), .TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
    .clk          (ref_clk),
    .rst_n        (rst_sync_n),
    .det_en_i     (det_en),
    .run_en_i     (run_en),
    .win_len_i    (win_len),
    .edge_pulse_i (edge_pulse),
    .valid_o      (valid),
    .result_o     (result)
  );

  fm_regs #(.REF_W(REF_W)) u_regs (
    .clk       (ref_clk),
    .rst_n     (rst_sync_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .valid_i   (valid),
    .result_i  (result),
    .win_len_o (win_len),
    .det_en_o  (det_en),
    .run_en_o  (run_en),
    .rdata     (rdata)
  );
endmodule

// File: tb/freqmeter_top_tb_top.sv
`timescale 1ns/1ps
module freqmeter_top_tb_top;
  localparam int REF_W   = 12;
  localparam int TMO     = 25000;
  localparam int REF_MAX = 4095;
  localparam logic [24:0] DET = 25'h1000000;

  logic        clk = 1'b0;
  logic        cut_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [24:0] wdata = '0;
  logic [31:0] rdata;
  int          cut_half = 12;
  int          n_checks = 0;
  int          n_errors = 0;

  freqmeter_top #(.REF_W(REF_W), .TIMEOUT_CYC(TMO)) dut_i (
    .ref_clk (clk), .rst_n (rst_n), .cut_clk (cut_clk),
    .wr_en (wr_en), .addr (addr), .wdata (wdata), .rdata (rdata)
  );

  always #4 clk = ~clk;
  always #(cut_half) cut_clk = ~cut_clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input int exp, input int tol);
    n_checks++;
    if (act < exp - tol || act > exp + tol) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d +/- %0d", req, act, exp, tol);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [24:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_valid(input int limit, output bit seen);
    logic [31:0] s;
    seen = 0;
    for (int i = 0; i < limit; i++) begin
      rd(2'd1, s);
      if (s[0]) begin seen = 1; break; end
    end
  endtask

  task automatic measure(input string req, input int half, input int n);
    bit seen; logic [31:0] r; int per;
    wr(2'd0, 25'd0);
    cut_half = half; per = (2 * half) / 8;
    repeat (10) @(negedge clk);
    wr(2'd1, 25'h100);
    wr(2'd0, DET | 25'(n));
    wait_valid(n * per + 50, seen);
    check(req, 32'(seen), 32'd1);
    rd(2'd2, r);
    check_near(req, int'(r), n * per, per + 4);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(2'd0, d); check("R1 ctrl", d, 32'd0);
    rd(2'd1, d); check("R1 status", d, 32'd0);
    rd(2'd2, d); check("R1 result", d, 32'd0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(2'd0, 25'h0ABCDEF); rd(2'd0, d); check("R2 window", d, 32'h00ABCDEF);
    wr(2'd0, DET | 25'h000123); rd(2'd0, d); check("R2 det bit", d, 32'h01000123);
    wr(2'd0, 25'd0);
    wr(2'd1, 25'h1FFFFFF); rd(2'd1, d); check("R3 status ro valid", d, 32'h100);
    wr(2'd1, 25'd0); rd(2'd1, d); check("R3 run clear", d, 32'h0);
    wr(2'd2, 25'h55); rd(2'd2, d); check("R4 result ro", d, 32'h0);
  endtask

  task automatic t_gated;
    bit seen; logic [31:0] d, r;
    wr(2'd0, 25'd0); cut_half = 12;
    wr(2'd1, 25'h0);
    wr(2'd0, DET | 25'd20);
    repeat (200) @(negedge clk);
    rd(2'd1, d); check("R6 no progress while gated", d, 32'h0);
    wr(2'd1, 25'h100);
    wait_valid(200, seen);
    check("R6 resumes", 32'(seen), 32'd1);
    rd(2'd2, r); check_near("R6 result only active cycles", int'(r), 60, 7);
  endtask

  task automatic t_abort;
    bit seen; logic [31:0] d, r;
    wr(2'd0, 25'd0); cut_half = 12;
    wr(2'd1, 25'h100);
    wr(2'd0, DET | 25'd1000);
    repeat (300) @(negedge clk);
    wr(2'd0, 25'd1000);
    rd(2'd1, d); check("R7 aborted no valid", d, 32'h100);
    wr(2'd0, DET | 25'd40);
    wait_valid(300, seen); check("R7 done", 32'(seen), 32'd1);
    wr(2'd0, 25'd40);
    rd(2'd1, d); check("R7 valid cleared", d, 32'h100);
    wr(2'd0, DET | 25'd50);
    wait_valid(300, seen); check("R7 restart", 32'(seen), 32'd1);
    rd(2'd2, r); check_near("R7 fresh count", int'(r), 150, 7);
  endtask

  task automatic t_saturate;
    bit seen; logic [31:0] r;
    wr(2'd0, 25'd0); cut_half = 40;
    wr(2'd1, 25'h100);
    wr(2'd0, DET | 25'd500);
    wait_valid(6000, seen);
    check("R8 valid at saturation", 32'(seen), 32'd1);
    rd(2'd2, r); check("R8 saturated", r, 32'(REF_MAX));
  endtask

  task automatic t_timeout;
    logic [31:0] d;
    wr(2'd0, 25'd0); cut_half = 12;
    wr(2'd1, 25'h100);
    wr(2'd0, DET | 25'd10000);
    repeat (TMO + 100) @(negedge clk);
    rd(2'd1, d); check("R9 no valid", d, 32'h100);
    rd(2'd2, d); check("R9 result zero", d, 32'h0);
    repeat (8000) @(negedge clk);
    rd(2'd1, d); check("R9 stays ended", d, 32'h100);
  endtask

  task automatic t_zero;
    logic [31:0] d;
    wr(2'd0, 25'd0); cut_half = 12;
    wr(2'd1, 25'h100);
    wr(2'd0, DET);
    repeat (TMO + 100) @(negedge clk);
    rd(2'd1, d); check("R10 zero window", d, 32'h100);
  endtask

  task automatic t_latch;
    bit seen; logic [31:0] r;
    wr(2'd0, 25'd0); cut_half = 12;
    wr(2'd1, 25'h100);
    wr(2'd0, DET | 25'd100);
    wr(2'd0, DET | 25'd5);
    wait_valid(400, seen); check("R11 done", 32'(seen), 32'd1);
    rd(2'd2, r); check_near("R11 latched window", int'(r), 300, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_layout();
    measure("R5 period 3", 12, 100);
    measure("R5 period 5", 20, 64);
    measure("R5 period 4", 16, 200);
    t_gated();
    t_abort();
    t_saturate();
    t_latch();
    t_timeout();
    t_zero();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule